// File: doc/BRIEF.md
# Programmable Multi-Phase Pulse Timer

This block generates the timing skeleton of a two-emitter optical measurement front end. A single free-running counter steps through a pulse repetition period in units of the timing clock, which is nominally 4 MHz. Fourteen outputs are each asserted while the counter lies inside that output's own programmed window. The outputs are:

- a drive pulse for each emitter;
- a sampling window for each emitter;
- a sampling window for each ambient-light phase;
- four converter-reset pulses;
- four conversion windows.

A one-clock strobe marks the last count of each period, so downstream data-ready logic can latch results.

All window bounds and the period length are 16-bit values loaded through a plain register write/read port. The block places no rules on the values. Windows may overlap or sit anywhere in the period. Equal bounds give a one-clock pulse, and a start above its end silences the output. Keeping the phases in a sensible order is left to the programmer. The intended order is emitter-B, then emitter-B ambient, then emitter-A, then emitter-A ambient. Each conversion should begin one clock after its reset pulse.

Top module: `pst_top`

## Requirements
- R1: After reset the counter is 0, every start, end and period register reads 0, and all outputs and the strobe are low.
- R2: Window k (0..13) has its start register at word address 2k+1 and its end register at 2k+2. The period register is at address 29 (1Dh). Reads return the last 16-bit value written. Addresses 0, 30 and 31 read 0, and writes to them change nothing.
- R3: While enabled, the counter runs 0, 1, ..., P and then returns to 0, where P is the period register. A period of P lasts P+1 clocks.
- R4: Output bit k is high exactly when start_k <= count <= end_k, using an unsigned compare. The output appears one clock after the counter holds that count. Bit order: 0 emitter-B sample, 1 emitter-B drive, 2 emitter-B ambient sample, 3 emitter-A sample, 4 emitter-A drive, 5 emitter-A ambient sample, 6..9 conversion windows, 10..13 converter-reset pulses.
- R5: When start equals end, the output is high for exactly one clock per period.
- R6: When start is greater than end, the output stays low for the whole period.
- R7: Overlapping windows are allowed, and each output follows its own bounds independently of the others.
- R8: If the period is rewritten to a value below the current count, the counter returns to 0 on the next clock.
- R9: While the enable input is low, the counter is held at 0 and all outputs and the strobe are low. After enable rises, the first output cycle corresponds to count 0.
- R10: The end-of-period strobe is high for one clock, aligned with the outputs for count P. When it is high, the counter has just returned to 0.
- R11: A register write changes the compare from the very next count. There is no deferral to the period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the counter at 0 and the outputs low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| win_out | output | 14 | Registered window outputs, bit order as in R4 |
| period_end | output | 1 | One-clock end-of-period strobe |

## Verification
A register write can land in the same cycle as the counter wrap decision. The sharpest case is a period rewrite while the counter already sits above the new value. The bench provokes this by waiting until its own model counter shows 15 under a period of 19, then writing a period of 5 in that cycle. The scoreboard's reference model compares with the old values at that edge and applies the write afterwards. Every later cycle's outputs and strobe are judged against that model, so a counter that runs on to 65535 or applies the write late shows up as a mismatch.

// File: rtl/pst_pkg.sv
package pst_pkg;
  // unsigned window membership, widths zero-extended to 32 bits
  function automatic logic in_window(input logic [31:0] cnt,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (lo <= cnt) && (cnt <= hi);
  endfunction

  // counter successor: wrap once the period bound is reached or passed
  function automatic logic [31:0] next_count(input logic [31:0] cnt,
                                             input logic [31:0] last);
    return (cnt >= last) ? 32'd0 : cnt + 32'd1;
  endfunction

  function automatic int unsigned start_addr(input int unsigned k);
    return 2 * k + 1;
  endfunction

  function automatic int unsigned end_addr(input int unsigned k);
    return 2 * k + 2;
  endfunction

  function automatic int unsigned period_addr(input int unsigned nwin);
    return 2 * nwin + 1;
  endfunction
endpackage

// File: rtl/pst_regfile.sv
module pst_regfile #(
  parameter int CNT_W   = 16,
  parameter int NUM_WIN = 14,
  parameter int ADDR_W  = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [CNT_W-1:0]                 wdata,
  output logic [NUM_WIN-1:0][CNT_W-1:0]    starts,
  output logic [NUM_WIN-1:0][CNT_W-1:0]    stops,
  output logic [CNT_W-1:0]                 period,
  output logic [CNT_W-1:0]                 rdata
);
  import pst_pkg::*;
  localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(period_addr(NUM_WIN));

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(start_addr(k));
    localparam logic [ADDR_W-1:0] EA = ADDR_W'(end_addr(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        starts[k] <= '0;
        stops[k]  <= '0;
      end else if (we) begin
        if (addr == SA) starts[k] <= wdata;
        if (addr == EA) stops[k]  <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  period <= '0;
    else if (we && addr == PER_A) period <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (addr == PER_A) rdata = period;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (addr == ADDR_W'(start_addr(k))) rdata = starts[k];
      if (addr == ADDR_W'(end_addr(k)))   rdata = stops[k];
    end
  end
endmodule

// File: rtl/pst_counter.sv
module pst_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  import pst_pkg::*;
  assign wrap = en && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (!en) cnt <= '0;
    else         cnt <= CNT_W'(next_count(32'(cnt), 32'(last)));
  end
endmodule

// File: rtl/pst_window.sv
module pst_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  output logic             active
);
  import pst_pkg::*;
  logic hit;
  assign hit = in_window(32'(cnt), 32'(lo), 32'(hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= en && hit;
  end
endmodule

// File: rtl/pst_top.sv
module pst_top #(
  parameter int CNT_W   = 16,
  parameter int NUM_WIN = 14,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  output logic [NUM_WIN-1:0] win_out,
  output logic               period_end
);
  logic [NUM_WIN-1:0][CNT_W-1:0] start_q;
  logic [NUM_WIN-1:0][CNT_W-1:0] end_q;
  logic [CNT_W-1:0]              period_q;
  logic [CNT_W-1:0]              cnt_q;
  logic                          wrap_now;

  pst_regfile #(.CNT_W(CNT_W), .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .starts(start_q), .stops(end_q), .period(period_q), .rdata(reg_rdata)
  );

  pst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .last(period_q),
    .cnt(cnt_q), .wrap(wrap_now)
  );

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_out
    pst_window #(.CNT_W(CNT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt_q),
      .lo(start_q[k]), .hi(end_q[k]), .active(win_out[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_end <= 1'b0;
    else        period_end <= wrap_now;
  end
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int CNT_W   = 16,
  parameter int NUM_WIN = 14
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          en,
  input logic [CNT_W-1:0]              cnt,
  input logic [CNT_W-1:0]              period,
  input logic [NUM_WIN-1:0][CNT_W-1:0] starts,
  input logic [NUM_WIN-1:0][CNT_W-1:0] stops,
  input logic [NUM_WIN-1:0]            win_out,
  input logic                          period_end
);
  // R3
  counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt < period) |=> (cnt == $past(cnt) + 1'b1));

  // R8
  counter_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt >= period) |=> (cnt == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && win_out == '0 && !period_end));

  // R10
  strobe_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (cnt == '0));

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_zero
    // R6
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(starts[k]) > $past(stops[k])) |-> !win_out[k]);
  end
endmodule

bind pst_top pst_checker #(.CNT_W(CNT_W), .NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt_q), .period(period_q),
  .starts(start_q), .stops(end_q), .win_out(win_out), .period_end(period_end)
);

// File: tb/pst_top_bench.sv
module pst_top_bench;
  localparam int NW = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [NW-1:0] win_out;
  logic        period_end;

  pst_top u_pst_top (
    .clk(clk), .rst_n(rst_n), .en(en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_out(win_out),
    .period_end(period_end)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [NW-1:0] w;
    logic          pe;
    string         tag;
  } item_t;

  item_t  sb[$];
  int     n_cmp = 0;
  int     n_bad = 0;
  string  cur_tag = "R1";
  bit     done = 1'b0;

  // reference model, written from the requirements
  logic [15:0] m_lo[NW];
  logic [15:0] m_hi[NW];
  logic [15:0] m_per;
  logic [15:0] m_cnt;

  always @(posedge clk) begin
    item_t it;
    it.tag = cur_tag;
    if (!rst_n) begin
      for (int k = 0; k < NW; k++) begin m_lo[k] = 0; m_hi[k] = 0; end
      m_per = 0; m_cnt = 0; it.w = '0; it.pe = 1'b0;
    end else if (!en) begin
      m_cnt = 0; it.w = '0; it.pe = 1'b0;
    end else begin
      for (int k = 0; k < NW; k++) it.w[k] = (m_lo[k] <= m_cnt) && (m_cnt <= m_hi[k]);
      it.pe = (m_cnt >= m_per);
      m_cnt = (m_cnt >= m_per) ? 16'd0 : m_cnt + 16'd1;
    end
    if (rst_n && reg_we) begin
      for (int k = 0; k < NW; k++) begin
        if (reg_addr == 5'(2*k+1)) m_lo[k] = reg_wdata;
        if (reg_addr == 5'(2*k+2)) m_hi[k] = reg_wdata;
      end
      if (reg_addr == 5'd29) m_per = reg_wdata;
    end
    sb.push_back(it);
  end

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (win_out !== it.w || period_end !== it.pe) begin
        n_bad++;
        if (n_bad < 25)
          $display("FAIL %s: win_out=%h period_end=%b expected win_out=%h period_end=%b",
                   it.tag, win_out, period_end, it.w, it.pe);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a;
    #1;
    n_cmp++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic run(input int n, input string tag);
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_win(input int k, input logic [15:0] lo, input logic [15:0] hi);
    wr(5'(2*k+1), lo);
    wr(5'(2*k+2), hi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state read back
    for (int a = 0; a < 32; a++) rd(5'(a), 16'h0000, "R1");
    rst_n = 1'b1;
    run(2, "R9");
    en = 1'b1;
    run(5, "R1");
    // R11: writes while running take effect immediately
    cur_tag = "R11";
    wr(5'd29, 16'd19);
    set_win(0, 3, 6);
    set_win(1, 2, 8);            // R7 overlaps window 0
    set_win(2, 5, 5);            // R5 single-clock pulse
    set_win(3, 9, 4);            // R6 suppressed
    set_win(5, 19, 19);          // last count of the period
    set_win(6, 10, 19);
    set_win(13, 16'hFFFF, 16'hFFFF);
    set_win(12, 16'h8000, 16'h0001); // R6 unsigned: large start
    run(25, "R4");
    run(25, "R5");
    run(25, "R7");
    run(25, "R10");
    // R2: read back and reserved addresses
    rd(5'd1, 16'd3, "R2");
    rd(5'd6, 16'd5, "R2");
    rd(5'd8, 16'd4, "R2");
    rd(5'd27, 16'hFFFF, "R2");
    rd(5'd29, 16'd19, "R2");
    cur_tag = "R2";
    wr(5'd0, 16'h1234);
    wr(5'd30, 16'h0000);
    wr(5'd31, 16'h0003);
    rd(5'd0, 16'h0000, "R2");
    rd(5'd30, 16'h0000, "R2");
    rd(5'd31, 16'h0000, "R2");
    rd(5'd2, 16'd6, "R2");
    run(22, "R2");
    // R8: shrink period below the running count
    cur_tag = "R8";
    while (m_cnt != 16'd15) @(negedge clk);
    wr(5'd29, 16'd5);
    run(20, "R8");
    // R3: short period
    cur_tag = "R3";
    wr(5'd29, 16'd3);
    run(20, "R3");
    // R9: disable mid-period, then restart at count 0
    while (m_cnt != 16'd2) @(negedge clk);
    en = 1'b0;
    run(8, "R9");
    en = 1'b1;
    run(12, "R9");
    // R10: period 0 strobes every clock
    cur_tag = "R10";
    wr(5'd29, 16'd0);
    run(8, "R10");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule